// File: doc/BRIEF.md
# Masked Data Watchpoint Unit

This block holds a small set of data watchpoint channels and compares every memory access on a load/store bus against them. Each channel keeps a watch address and a control word. The control word enables breaking on stores, on loads, or on both, and carries a mask field that selects which low address bits are ignored. A channel raises its hit line in the same cycle as the access, so the surrounding pipeline can stop the access before it takes effect.

The effective mask is the programmed field with ones in every address bit above it. The watched region is therefore an aligned block whose base is the watch address with the masked bits cleared, and whose size is the inverted mask plus one. A field that is not a run of ones followed by a run of zeros would not describe such a block. The unit truncates the field below its first zero, counting down from the most significant bit, and keeps a per-channel error flag that records that the last control write needed this correction.

Top module: `dbk_watch_top`

## Requirements
- R1: After a synchronous active-high reset every channel has both enables clear, a zero mask field, a zero watch address and a clear error flag, so no hit is raised.
- R2: A write to the address or control of channel `cfg_ch` takes effect at the next rising clock edge and leaves every other channel unchanged. A channel index of `NUM_CH` or more writes nothing.
- R3: Control word layout: bit 0 is the store enable, bit 1 is the load enable, and bits [MW+1:2] are the mask field. A channel whose enables are both clear never hits, starting in the cycle after that control write.
- R4: With the store enable set, a channel hits on writes (`acc_write`=1). With the load enable set, it hits on reads (`acc_write`=0). A direction whose enable is clear never hits.
- R5: The effective mask is the stored mask field in bits [MW-1:0] with every bit from MW up to AW-1 set to one.
- R6: The watched region starts at the watch address ANDed with the effective mask and is (inverted effective mask + 1) bytes long.
- R7: If the written mask field is not contiguous, the stored field keeps its leading ones from bit MW-1 down to the first zero, and every bit below that zero is cleared.
- R8: A control write sets `mask_err` for that channel when the written field is not contiguous and clears it when the field is contiguous. Address writes and writes to other channels leave the flag unchanged.
- R9: `acc_size` 0 means 1 byte, 1 means 2 bytes, and 2 or 3 mean 4 bytes. An access hits when any byte it touches (addresses wrap modulo 2^AW) lies in the watched region.
- R10: `hit` is combinational from the current access inputs and is zero whenever `acc_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_addr_we | input | 1 | Write `cfg_wdata` to the watch address of channel `cfg_ch` |
| cfg_ctrl_we | input | 1 | Write `cfg_wdata` to the control word of channel `cfg_ch` |
| cfg_ch | input | CHW | Channel index for configuration writes |
| cfg_wdata | input | AW | Configuration write data |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_size | input | 2 | Access size code |
| acc_addr | input | AW | Byte address of the access |
| hit | output | NUM_CH | Per-channel watchpoint hit, same cycle |
| mask_err | output | NUM_CH | Per-channel flag: last control write had a non-contiguous mask |

## Verification
On every cycle the assertions check that a disabled channel and a disabled direction never hit, that no hit appears without a valid access, that the stored mask always describes an aligned power-of-two block, and that the error flag holds its value across cycles without a control write. Only the bench's scenarios show that the region base, length, byte overlap and address wrap are right. They also show that each corrected mask equals the truncation of the written field, and that channels do not disturb each other. For these, the bench sweeps every mask field against every address, size and direction of a small configuration.

// File: rtl/dbk_pkg.sv
package dbk_pkg;

    localparam int MAX_ACC_BYTES = 4;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_WORDX = 2'd3
    } acc_size_e;

    typedef struct packed {
        logic ld;
        logic st;
    } brk_en_t;

    function automatic logic [2:0] sz_bytes(input logic [1:0] code);
        case (acc_size_e'(code))
            SZ_BYTE: return 3'd1;
            SZ_HALF: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dbk_mask_fix.sv
module dbk_mask_fix #(
    parameter int MW = 6
) (
    input  logic [MW-1:0] raw,
    output logic [MW-1:0] fixed,
    output logic          broken
);
    always_comb begin
        logic run;
        run = 1'b1;
        for (int i = MW - 1; i >= 0; i--) begin
            run      = run & raw[i];
            fixed[i] = run;
        end
        broken = (fixed != raw);
    end
endmodule

// File: rtl/dbk_region_match.sv
module dbk_region_match #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base_addr,
    input  logic [AW-1:0] mask,
    input  logic [AW-1:0] acc_addr,
    input  logic [2:0]    nbytes,
    output logic          touched
);
    import dbk_pkg::*;

    logic [MAX_ACC_BYTES-1:0] in_v;

    for (genvar b = 0; b < MAX_ACC_BYTES; b++) begin : g_byte
        logic [AW-1:0] a_b;
        assign a_b     = acc_addr + AW'(b);
        assign in_v[b] = (3'(b) < nbytes) && (((a_b ^ base_addr) & mask) == '0);
    end

    assign touched = |in_v;
endmodule

// File: rtl/dbk_channel.sv
module dbk_channel #(
    parameter int AW = 32,
    parameter int MW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          addr_we,
    input  logic          ctrl_we,
    input  logic [AW-1:0] wdata,
    input  logic          acc_valid,
    input  logic          acc_write,
    input  logic [1:0]    acc_size,
    input  logic [AW-1:0] acc_addr,
    output logic          hit,
    output logic          err
);
    import dbk_pkg::*;

    localparam int CW = MW + 2;

    brk_en_t       en_q;
    logic [MW-1:0] fld_q;
    logic [AW-1:0] addr_q;
    logic          err_q;
    logic [MW-1:0] fix_fld;
    logic          fix_bad;
    logic [AW-1:0] eff_mask;
    logic          any_in;
    logic          dir_ok;

    dbk_mask_fix #(.MW(MW)) u_fix (
        .raw    (wdata[CW-1:2]),
        .fixed  (fix_fld),
        .broken (fix_bad)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q   <= '0;
            fld_q  <= '0;
            addr_q <= '0;
            err_q  <= 1'b0;
        end else begin
            if (addr_we) begin
                addr_q <= wdata;
            end
            if (ctrl_we) begin
                en_q.st <= wdata[0];
                en_q.ld <= wdata[1];
                fld_q   <= fix_fld;
                err_q   <= fix_bad;
            end
        end
    end

    assign eff_mask = {{(AW - MW){1'b1}}, fld_q};

    dbk_region_match #(.AW(AW)) u_match (
        .base_addr (addr_q),
        .mask      (eff_mask),
        .acc_addr  (acc_addr),
        .nbytes    (sz_bytes(acc_size)),
        .touched   (any_in)
    );

    assign dir_ok = acc_write ? en_q.st : en_q.ld;
    assign hit    = acc_valid && dir_ok && any_in;
    assign err    = err_q;

    assert_idle_no_hit_R3: assert property (@(posedge clk) disable iff (rst)
        (!en_q.st && !en_q.ld) |-> !hit);

    assert_store_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_write && !en_q.st) |-> !hit);

    assert_load_gate_R4: assert property (@(posedge clk) disable iff (rst)
        (!acc_write && !en_q.ld) |-> !hit);

    assert_mask_aligned_R7: assert property (@(posedge clk) disable iff (rst)
        (((~eff_mask) + AW'(1)) & (~eff_mask)) == '0);

    assert_err_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !ctrl_we |=> $stable(err_q));

    assert_no_valid_no_hit_R10: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> !hit);
endmodule

// File: rtl/dbk_watch_top.sv
module dbk_watch_top #(
    parameter int NUM_CH = 4,
    parameter int AW     = 32,
    parameter int MW     = 6,
    localparam int CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_addr_we,
    input  logic              cfg_ctrl_we,
    input  logic [CHW-1:0]    cfg_ch,
    input  logic [AW-1:0]     cfg_wdata,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_size,
    input  logic [AW-1:0]     acc_addr,
    output logic [NUM_CH-1:0] hit,
    output logic [NUM_CH-1:0] mask_err
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic sel;
        assign sel = (cfg_ch == CHW'(g));

        dbk_channel #(.AW(AW), .MW(MW)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .addr_we   (cfg_addr_we && sel),
            .ctrl_we   (cfg_ctrl_we && sel),
            .wdata     (cfg_wdata),
            .acc_valid (acc_valid),
            .acc_write (acc_write),
            .acc_size  (acc_size),
            .acc_addr  (acc_addr),
            .hit       (hit[g]),
            .err       (mask_err[g])
        );
    end
endmodule

// File: tb/dbk_watch_top_bench.sv
`timescale 1ns/1ps
module dbk_watch_top_bench;
    localparam int NCH = 2;
    localparam int BAW = 8;
    localparam int BMW = 4;
    localparam int SPAN = 1 << BAW;
    localparam int FTOP = (1 << BMW) - 1;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_addr_we = 1'b0;
    logic           cfg_ctrl_we = 1'b0;
    logic [0:0]     cfg_ch = '0;
    logic [BAW-1:0] cfg_wdata = '0;
    logic           acc_valid = 1'b0;
    logic           acc_write = 1'b0;
    logic [1:0]     acc_size = '0;
    logic [BAW-1:0] acc_addr = '0;
    logic [NCH-1:0] hit;
    logic [NCH-1:0] mask_err;

    int tests = 0;
    int fails = 0;
    int m_addr [NCH];
    int m_ctrl [NCH];

    always #4 clk = ~clk;

    dbk_watch_top #(.NUM_CH(NCH), .AW(BAW), .MW(BMW)) u_dbk_watch_top (
        .clk, .rst, .cfg_addr_we, .cfg_ctrl_we, .cfg_ch, .cfg_wdata,
        .acc_valid, .acc_write, .acc_size, .acc_addr, .hit, .mask_err
    );

    function automatic int fixed_field(int f);
        int k = 0;
        for (int i = BMW - 1; i >= 0; i--) begin
            if (((f >> i) & 1) == 1) k++;
            else break;
        end
        return (k == 0) ? 0 : (FTOP - ((1 << (BMW - k)) - 1));
    endfunction

    function automatic bit exp_hit(int ch, int a, int sz, int wr);
        int f    = (m_ctrl[ch] >> 2) & FTOP;
        int mask = (SPAN - 1 - FTOP) | fixed_field(f);
        int base = m_addr[ch] & mask;
        int len  = SPAN - mask;
        int nb   = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        bit en   = wr ? m_ctrl[ch][0] : m_ctrl[ch][1];
        bit inr  = 1'b0;
        for (int b = 0; b < nb; b++) begin
            int by = (a + b) % SPAN;
            if (((by - base + SPAN) % SPAN) < len) inr = 1'b1;
        end
        return en && inr;
    endfunction

    function automatic bit exp_err(int ch);
        int f = (m_ctrl[ch] >> 2) & FTOP;
        return fixed_field(f) != f;
    endfunction

    task automatic chk(bit ok, string tag, int act, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("[TB] FAIL %s: got %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic wr_cfg(int ch, bit is_ctrl, int val);
        @(negedge clk);
        cfg_ch      = 1'(ch);
        cfg_wdata   = BAW'(val);
        cfg_addr_we = !is_ctrl;
        cfg_ctrl_we = is_ctrl;
        @(negedge clk);
        cfg_addr_we = 1'b0;
        cfg_ctrl_we = 1'b0;
        if (ch < NCH) begin
            if (is_ctrl) m_ctrl[ch] = val & ((1 << (BMW + 2)) - 1);
            else         m_addr[ch] = val & (SPAN - 1);
        end
    endtask

    function automatic int exp_vec(int a, int sz, int wr);
        int v = 0;
        for (int c = 0; c < NCH; c++) if (exp_hit(c, a, sz, wr)) v |= (1 << c);
        return v;
    endfunction

    // R5 R6 R7 R9 R10: every address, size and direction against the model
    task automatic sweep_all(string tag);
        for (int a = 0; a < SPAN; a++)
            for (int sz = 0; sz < 4; sz++)
                for (int wr = 0; wr < 2; wr++) begin
                    @(negedge clk);
                    acc_valid = 1'b1;
                    acc_addr  = BAW'(a);
                    acc_size  = 2'(sz);
                    acc_write = wr[0];
                    #2;
                    chk(int'(hit) == exp_vec(a, sz, wr), tag, int'(hit), exp_vec(a, sz, wr));
                end
        acc_valid = 1'b0;
    endtask

    task automatic chk_err(string tag);
        int e = 0;
        for (int c = 0; c < NCH; c++) if (exp_err(c)) e |= (1 << c);
        #2;
        chk(int'(mask_err) == e, tag, int'(mask_err), e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("[TB] FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin m_addr[c] = 0; m_ctrl[c] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = '0; acc_size = 2'd2;
        #2;
        chk(hit == '0, "R1 hit after reset", int'(hit), 0);
        chk(mask_err == '0, "R1 err after reset", int'(mask_err), 0);
        acc_write = 1'b0;
        #1;
        chk(hit == '0, "R1 load hit after reset", int'(hit), 0);
        acc_valid = 1'b0;

        // R5 R6 R7 R8 R9: every mask field on channel 0, both directions
        wr_cfg(0, 1'b0, 8'hB7);
        for (int f = 0; f <= FTOP; f++) begin
            wr_cfg(0, 1'b1, (f << 2) | 3);
            chk_err("R7 R8 err after ctrl write");
            sweep_all("R5 R6 R9 sweep");
        end

        // R4: store only, then load only
        wr_cfg(0, 1'b1, (4'b1100 << 2) | 1);
        sweep_all("R4 store only");
        wr_cfg(0, 1'b1, (4'b1110 << 2) | 2);
        sweep_all("R4 load only");

        // R3: both enables clear disables the channel
        wr_cfg(0, 1'b1, (4'b1111 << 2));
        sweep_all("R3 disabled");

        // R2 R8: two channels, independent writes
        wr_cfg(0, 1'b1, (4'b1010 << 2) | 3);
        wr_cfg(1, 1'b0, 8'h3F);
        wr_cfg(1, 1'b1, (4'b1000 << 2) | 3);
        chk_err("R2 R8 err per channel");
        sweep_all("R2 two channels");
        wr_cfg(1, 1'b0, 8'hFE);
        chk_err("R8 err kept over addr write");
        sweep_all("R2 wrap channel 1");
        wr_cfg(1, 1'b1, (4'b0110 << 2) | 1);
        chk_err("R8 err set on channel 1 only");
        wr_cfg(0, 1'b1, (4'b1100 << 2) | 3);
        chk_err("R8 err cleared on contiguous write");

        // R10: no hit without a valid access
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b1; acc_size = 2'd2; acc_addr = 8'hB4;
        #2;
        chk(hit == '0, "R10 invalid access", int'(hit), 0);
        acc_valid = 1'b1;
        #1;
        chk(int'(hit) == exp_vec(8'hB4, 2, 1), "R10 same cycle hit",
            int'(hit), exp_vec(8'hB4, 2, 1));
        acc_valid = 1'b0;

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule